// File: doc/BRIEF.md
# Boundary-Scan Data-Register Path

This block is the data-register half of an IEEE 1149.1 test port. A separate TAP state machine supplies the capture, shift and update strobes and the test-logic-reset strobe. A separate instruction register supplies a 3-bit instruction code. From these, the block picks the serial path between TDI and TDO. There are three paths: a one-bit bypass stage, a boundary-scan chain with two cells per pin, and a one-bit test-control stage that has a parallel hold copy.

The block also sits between the functional core and the pads. In normal operation it passes the core's output values and output enables through unchanged. It replaces them with the boundary-scan update cells when EXTEST or CLAMP is active, and it forces every enable low when HIGHZ is active. HIGHZ and CLAMP also request an internal system reset while they are active.

Shift stages sample TDI on the rising edge of TCK. TDO and every parallel update register change on the falling edge of TCK.

Top module: `tdr_path`

## Requirements
- R1: The instruction codes are EXTEST=000, SAMPLE/PRELOAD=001, HIGHZ=010, CLAMP=011, TEST_CTRL=100 and BYPASS=111. Any other code behaves as BYPASS, with no pin override and no reset request. Under BYPASS, HIGHZ, CLAMP or an undefined code, the path is a single bit that loads 0 on capture-DR, so each TDI bit shifted in appears on TDO after one TCK cycle.
- R2: TDO changes only on the falling edge of TCK. A rising edge alone leaves TDO unchanged.
- R3: Under SAMPLE/PRELOAD, capture-DR loads cell 2i with pin_in[i] and cell 2i+1 with core_oe[i]. Shifting then presents cell 0 on TDO first, followed by the cells in increasing index order.
- R4: Under SAMPLE/PRELOAD or EXTEST, update-DR copies the chain into the update cells on the falling edge of TCK. The first bit shifted in lands in cell 0.
- R5: Under EXTEST, pad_out[i] equals update cell 2i and pad_oe[i] equals update cell 2i+1, and no reset is requested.
- R6: Under CLAMP, the pads take the update-cell values exactly as in R5, and sys_rst_req is 1. Shift and update under CLAMP leave the update cells unchanged.
- R7: Under HIGHZ, every pad_oe bit is 0 and sys_rst_req is 1.
- R8: Under TEST_CTRL, the path is a one-bit stage that loads the current tctl_hold value on capture-DR. Update-DR copies the stage into tctl_hold on the falling edge of TCK.
- R9: While tlr is 1, the pads pass the core values and sys_rst_req is 0. tlr also clears tctl_hold, the update cells and TDO.
- R10: Under SAMPLE/PRELOAD, TEST_CTRL or BYPASS, pad_out equals core_out and pad_oe equals core_oe, including while the chain is capturing and shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tdi | input | 1 | Serial test data in |
| instr | input | 3 | Decoded current instruction code |
| cap_dr | input | 1 | TAP is in capture-DR |
| shf_dr | input | 1 | TAP is in shift-DR |
| upd_dr | input | 1 | TAP is in update-DR |
| tlr | input | 1 | TAP is in test-logic-reset |
| core_out | input | NUM_PINS | Functional output values from the core |
| core_oe | input | NUM_PINS | Functional output enables from the core |
| pin_in | input | NUM_PINS | Pin states seen at the pads |
| tdo | output | 1 | Serial test data out |
| pad_out | output | NUM_PINS | Output values to the pad drivers |
| pad_oe | output | NUM_PINS | Output enables to the pad drivers |
| tctl_hold | output | 1 | Held test-control bit |
| sys_rst_req | output | 1 | Internal system reset request |

## Verification
The hardest case to reach from the ports is the claim in R6 that CLAMP leaves the update cells untouched. The cells are only visible while an instruction drives the pads from them, and CLAMP itself shows the same cells. So the stimulus first preloads a known pattern and confirms it under EXTEST. It then switches to CLAMP and runs a full shift and update with a contrasting TDI pattern. Finally it checks the pads under CLAMP and again after returning to EXTEST. A similar round trip through capture-DR proves that the test-control hold value survives shifting without an update.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

   typedef enum logic [2:0] {
      TI_EXTEST = 3'b000,
      TI_SAMPLE = 3'b001,
      TI_HIGHZ  = 3'b010,
      TI_CLAMP  = 3'b011,
      TI_TCTL   = 3'b100,
      TI_BYPASS = 3'b111
   } tinstr_e;

   typedef enum logic [1:0] {
      PATH_BYP  = 2'd0,
      PATH_BSR  = 2'd1,
      PATH_TCTL = 2'd2
   } path_e;

   typedef enum logic [1:0] {
      OVR_NONE  = 2'd0,
      OVR_CELLS = 2'd1,
      OVR_OFF   = 2'd2
   } ovr_e;

   function automatic path_e path_of(input logic [2:0] code);
      case (code)
         TI_EXTEST, TI_SAMPLE: path_of = PATH_BSR;
         TI_TCTL:              path_of = PATH_TCTL;
         default:              path_of = PATH_BYP;
      endcase
   endfunction

   function automatic ovr_e ovr_of(input logic [2:0] code);
      case (code)
         TI_EXTEST, TI_CLAMP: ovr_of = OVR_CELLS;
         TI_HIGHZ:            ovr_of = OVR_OFF;
         default:             ovr_of = OVR_NONE;
      endcase
   endfunction

   function automatic logic rst_of(input logic [2:0] code);
      rst_of = (code == TI_HIGHZ) || (code == TI_CLAMP);
   endfunction

endpackage

// File: rtl/tdr_bit.sv
// One-bit serial stage with an optional parallel hold copy.
module tdr_bit #(
   parameter bit HAS_HOLD = 1'b0
) (
   input  logic tck,
   input  logic clr,
   input  logic sel,
   input  logic cap,
   input  logic shf,
   input  logic upd,
   input  logic tdi,
   output logic stage_q,
   output logic hold_q
);

   logic cap_val;

   // Capture reloads the hold copy when present, else a constant 0.
   assign cap_val = HAS_HOLD ? hold_q : 1'b0;

   always_ff @(posedge tck) begin
      if (clr)
         stage_q <= 1'b0;
      else if (sel && cap)
         stage_q <= cap_val;
      else if (sel && shf)
         stage_q <= tdi;
   end

   always_ff @(negedge tck) begin
      if (clr)
         hold_q <= 1'b0;
      else if (sel && upd)
         hold_q <= HAS_HOLD ? stage_q : 1'b0;
   end

endmodule

// File: rtl/tdr_bsr.sv
// Boundary-scan chain: two cells per pin (value, enable) plus update cells.
module tdr_bsr #(
   parameter int NUM_PINS = 4
) (
   input  logic                tck,
   input  logic                clr,
   input  logic                sel,
   input  logic                cap,
   input  logic                shf,
   input  logic                upd,
   input  logic                tdi,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] core_oe,
   output logic                so,
   output logic [NUM_PINS-1:0] upd_data,
   output logic [NUM_PINS-1:0] upd_en
);

   localparam int CHAIN_LEN = 2 * NUM_PINS;

   logic [CHAIN_LEN-1:0] cap_vec;
   logic [CHAIN_LEN-1:0] sh_q;
   logic [CHAIN_LEN-1:0] cell_q;

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         assign cap_vec[2*i]   = pin_in[i];
         assign cap_vec[2*i+1] = core_oe[i];
         assign upd_data[i]    = cell_q[2*i];
         assign upd_en[i]      = cell_q[2*i+1];
      end
   endgenerate

   generate
      if (CHAIN_LEN == 1) begin : g_short
         always_ff @(posedge tck) begin
            if (clr)
               sh_q <= '0;
            else if (sel && cap)
               sh_q <= cap_vec;
            else if (sel && shf)
               sh_q <= tdi;
         end
      end else begin : g_long
         always_ff @(posedge tck) begin
            if (clr)
               sh_q <= '0;
            else if (sel && cap)
               sh_q <= cap_vec;
            else if (sel && shf)
               sh_q <= {tdi, sh_q[CHAIN_LEN-1:1]};
         end
      end
   endgenerate

   assign so = sh_q[0];

   always_ff @(negedge tck) begin
      if (clr)
         cell_q <= '0;
      else if (sel && upd)
         cell_q <= sh_q;
   end

endmodule

// File: rtl/tdr_pad_mux.sv
// Per-pin selection between functional values and test overrides.
module tdr_pad_mux
   import tdr_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  ovr_e                mode,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] cell_out,
   input  logic [NUM_PINS-1:0] cell_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
         always_comb begin
            case (mode)
               OVR_CELLS: begin
                  pad_out[i] = cell_out[i];
                  pad_oe[i]  = cell_oe[i];
               end
               OVR_OFF: begin
                  pad_out[i] = core_out[i];
                  pad_oe[i]  = 1'b0;
               end
               default: begin
                  pad_out[i] = core_out[i];
                  pad_oe[i]  = core_oe[i];
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/tdr_path.sv
module tdr_path
   import tdr_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  logic                tck,
   input  logic                tdi,
   input  logic [2:0]          instr,
   input  logic                cap_dr,
   input  logic                shf_dr,
   input  logic                upd_dr,
   input  logic                tlr,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic                tdo,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                tctl_hold,
   output logic                sys_rst_req
);

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("tdr_path: NUM_PINS must be at least 1");
      end
   endgenerate

   path_e path;
   ovr_e  mode;
   logic  byp_q, byp_hold, tc_q, bsr_so, ser;
   logic [NUM_PINS-1:0] cell_out, cell_oe;

   assign path        = path_of(instr);
   assign mode        = tlr ? OVR_NONE : ovr_of(instr);
   assign sys_rst_req = !tlr && rst_of(instr);

   tdr_bit #(.HAS_HOLD(1'b0)) i_byp (
      .tck(tck), .clr(tlr), .sel(path == PATH_BYP),
      .cap(cap_dr), .shf(shf_dr), .upd(upd_dr), .tdi(tdi),
      .stage_q(byp_q), .hold_q(byp_hold)
   );

   tdr_bit #(.HAS_HOLD(1'b1)) i_tctl (
      .tck(tck), .clr(tlr), .sel(path == PATH_TCTL),
      .cap(cap_dr), .shf(shf_dr), .upd(upd_dr), .tdi(tdi),
      .stage_q(tc_q), .hold_q(tctl_hold)
   );

   tdr_bsr #(.NUM_PINS(NUM_PINS)) i_bsr (
      .tck(tck), .clr(tlr), .sel(path == PATH_BSR),
      .cap(cap_dr), .shf(shf_dr), .upd(upd_dr), .tdi(tdi),
      .pin_in(pin_in), .core_oe(core_oe), .so(bsr_so),
      .upd_data(cell_out), .upd_en(cell_oe)
   );

   tdr_pad_mux #(.NUM_PINS(NUM_PINS)) i_pads (
      .mode(mode), .core_out(core_out), .core_oe(core_oe),
      .cell_out(cell_out), .cell_oe(cell_oe),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // The bypass hold copy is always 0; fold it into the serial path.
   always_comb begin
      case (path)
         PATH_BSR:  ser = bsr_so;
         PATH_TCTL: ser = tc_q;
         default:   ser = byp_q | byp_hold;
      endcase
   end

   always_ff @(negedge tck) begin
      if (tlr)
         tdo <= 1'b0;
      else
         tdo <= ser;
   end

endmodule

// File: rtl/tdr_path_chk.sv
module tdr_path_chk #(
   parameter int NUM_PINS = 4
) (
   input logic                tck,
   input logic                tlr,
   input logic [2:0]          instr,
   input logic                upd_dr,
   input logic                tdo,
   input logic                byp_q,
   input logic                tc_q,
   input logic                tctl_hold,
   input logic                sys_rst_req,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] core_out,
   input logic [NUM_PINS-1:0] core_oe,
   input logic [NUM_PINS-1:0] cell_out,
   input logic [NUM_PINS-1:0] cell_oe
);

   a_r1_bypass_delay: assert property (@(negedge tck) disable iff (tlr)
      (instr == 3'b111) |=> (tdo == $past(byp_q)));

   a_r8_hold_copy: assert property (@(negedge tck) disable iff (tlr)
      (instr == 3'b100 && upd_dr) |=> (tctl_hold == $past(tc_q)));

   a_r5_extest_drive: assert property (@(posedge tck) disable iff (tlr)
      (instr == 3'b000) |-> (pad_out == cell_out && pad_oe == cell_oe && !sys_rst_req));

   a_r6_clamp_frozen: assert property (@(negedge tck) disable iff (tlr)
      (instr == 3'b011 && $past(instr) == 3'b011) |-> ($stable(pad_out) && $stable(pad_oe) && sys_rst_req));

   a_r7_highz_off: assert property (@(posedge tck) disable iff (tlr)
      (instr == 3'b010) |-> (pad_oe == '0 && sys_rst_req));

   a_r9_tlr_release: assert property (@(posedge tck)
      tlr |-> (!sys_rst_req && pad_out == core_out && pad_oe == core_oe));

   a_r10_passthrough: assert property (@(posedge tck) disable iff (tlr)
      (instr == 3'b001) |-> (pad_out == core_out && pad_oe == core_oe));

endmodule

bind tdr_path tdr_path_chk #(.NUM_PINS(NUM_PINS)) i_tdr_path_chk (
   .tck(tck), .tlr(tlr), .instr(instr), .upd_dr(upd_dr), .tdo(tdo),
   .byp_q(byp_q), .tc_q(tc_q), .tctl_hold(tctl_hold),
   .sys_rst_req(sys_rst_req), .pad_out(pad_out), .pad_oe(pad_oe),
   .core_out(core_out), .core_oe(core_oe),
   .cell_out(cell_out), .cell_oe(cell_oe)
);

// File: tb/test_tdr_path.sv
`timescale 1ns/1ps
module test_tdr_path;

   localparam int NP = 4;
   localparam int L  = 2 * NP;

   logic          tck = 1'b0;
   logic          tdi = 1'b0;
   logic [2:0]    instr = 3'b111;
   logic          cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0;
   logic          tlr = 1'b1;
   logic [NP-1:0] core_out = 4'b1010, core_oe = 4'b0110, pin_in = 4'b0011;
   logic          tdo, tctl_hold, sys_rst_req;
   logic [NP-1:0] pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 tck = ~tck;

   tdr_path #(.NUM_PINS(NP)) i_tdr_path (
      .tck(tck), .tdi(tdi), .instr(instr), .cap_dr(cap_dr), .shf_dr(shf_dr),
      .upd_dr(upd_dr), .tlr(tlr), .core_out(core_out), .core_oe(core_oe),
      .pin_in(pin_in), .tdo(tdo), .pad_out(pad_out), .pad_oe(pad_oe),
      .tctl_hold(tctl_hold), .sys_rst_req(sys_rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic preload(input logic [L-1:0] v);
      instr = 3'b001;
      shf_dr = 1'b1;
      for (int k = 0; k < L; k++) begin
         tdi = v[k];
         cyc();
      end
      shf_dr = 1'b0;
      upd_dr = 1'b1;
      cyc();
      upd_dr = 1'b0;
   endtask

   function automatic logic [NP-1:0] evens(input logic [L-1:0] v);
      for (int i = 0; i < NP; i++) evens[i] = v[2*i];
   endfunction

   function automatic logic [NP-1:0] odds(input logic [L-1:0] v);
      for (int i = 0; i < NP; i++) odds[i] = v[2*i+1];
   endfunction

   task automatic t_reset();
      cyc(); cyc();
      chk("R9 tdo after reset", tdo, 0);
      chk("R9 hold after reset", tctl_hold, 0);
      chk("R9 no reset request", sys_rst_req, 0);
      chk("R9 pad_out passes core", pad_out, core_out);
      chk("R9 pad_oe passes core", pad_oe, core_oe);
      tlr = 1'b0;
      cyc();
   endtask

   task automatic t_bypass(input logic [2:0] code, input string req);
      logic [7:0] pat = 8'b1011_0010;
      instr = code;
      cap_dr = 1'b1; cyc(); cap_dr = 1'b0;
      chk({req, " capture loads 0"}, tdo, 0);
      shf_dr = 1'b1;
      for (int k = 0; k < 8; k++) begin
         tdi = pat[k];
         cyc();
         chk({req, " one-bit delay"}, tdo, pat[k]);
      end
      shf_dr = 1'b0;
   endtask

   task automatic t_edge();
      instr = 3'b111; shf_dr = 1'b1; tdi = 1'b0; cyc();
      tdi = 1'b1;
      @(posedge tck); #1;
      chk("R2 tdo holds through rising edge", tdo, 0);
      @(negedge tck); #1;
      chk("R2 tdo moves on falling edge", tdo, 1);
      shf_dr = 1'b0;
   endtask

   task automatic t_sample();
      logic [L-1:0] exp;
      pin_in = 4'b1001; core_oe = 4'b0101;
      for (int i = 0; i < NP; i++) begin
         exp[2*i] = pin_in[i]; exp[2*i+1] = core_oe[i];
      end
      instr = 3'b001;
      cap_dr = 1'b1; cyc(); cap_dr = 1'b0;
      chk("R3 cell 0 first", tdo, exp[0]);
      chk("R10 pads pass in sample", {pad_out, pad_oe}, {core_out, core_oe});
      shf_dr = 1'b1; tdi = 1'b0;
      for (int k = 1; k < L; k++) begin
         cyc();
         chk("R3 cell order", tdo, exp[k]);
      end
      shf_dr = 1'b0;
      chk("R10 pads pass during shift", {pad_out, pad_oe}, {core_out, core_oe});
   endtask

   task automatic t_extest();
      logic [L-1:0] v = 8'b1101_0110;
      preload(v);
      chk("R10 pads pass after preload", {pad_out, pad_oe}, {core_out, core_oe});
      instr = 3'b000; #1;
      chk("R4 R5 pad_out from cells", pad_out, evens(v));
      chk("R4 R5 pad_oe from cells", pad_oe, odds(v));
      chk("R5 no reset request", sys_rst_req, 0);
      v = 8'b0011_1001;
      shf_dr = 1'b1;
      for (int k = 0; k < L; k++) begin tdi = v[k]; cyc(); end
      shf_dr = 1'b0; upd_dr = 1'b1; cyc(); upd_dr = 1'b0;
      chk("R4 update under extest", {pad_out, pad_oe}, {evens(v), odds(v)});
   endtask

   task automatic t_clamp();
      logic [L-1:0] v = 8'b1010_0101;
      preload(v);
      instr = 3'b011; #1;
      chk("R6 clamp pad_out", pad_out, evens(v));
      chk("R6 clamp pad_oe", pad_oe, odds(v));
      chk("R6 clamp reset request", sys_rst_req, 1);
      t_bypass(3'b011, "R1 R6 clamp path");
      shf_dr = 1'b1;
      for (int k = 0; k < L; k++) begin tdi = ~v[k]; cyc(); end
      shf_dr = 1'b0; upd_dr = 1'b1; cyc(); upd_dr = 1'b0;
      chk("R6 cells frozen under clamp", {pad_out, pad_oe}, {evens(v), odds(v)});
      instr = 3'b000; #1;
      chk("R6 cells frozen seen via extest", {pad_out, pad_oe}, {evens(v), odds(v)});
   endtask

   task automatic t_highz();
      instr = 3'b010; #1;
      chk("R7 all enables off", pad_oe, 0);
      chk("R7 reset request", sys_rst_req, 1);
      t_bypass(3'b010, "R1 highz path");
      chk("R7 enables still off", pad_oe, 0);
   endtask

   task automatic t_tctl();
      instr = 3'b100;
      shf_dr = 1'b1; tdi = 1'b1; cyc(); shf_dr = 1'b0;
      chk("R8 stage on tdo", tdo, 1);
      chk("R8 hold waits for update", tctl_hold, 0);
      chk("R10 pads pass in test-ctrl", {pad_out, pad_oe}, {core_out, core_oe});
      upd_dr = 1'b1; cyc(); upd_dr = 1'b0;
      chk("R8 hold loaded", tctl_hold, 1);
      shf_dr = 1'b1; tdi = 1'b0; cyc(); shf_dr = 1'b0;
      chk("R8 stage cleared", tdo, 0);
      cap_dr = 1'b1; cyc(); cap_dr = 1'b0;
      chk("R8 capture reloads hold", tdo, 1);
      chk("R8 hold unchanged without update", tctl_hold, 1);
   endtask

   task automatic t_undef();
      instr = 3'b101; #1;
      chk("R1 undefined code no override", {pad_out, pad_oe}, {core_out, core_oe});
      chk("R1 undefined code no reset", sys_rst_req, 0);
      t_bypass(3'b110, "R1 undefined code path");
   endtask

   task automatic t_tlr();
      preload(8'b1111_1111);
      instr = 3'b000; #1;
      chk("R9 precondition cells set", pad_oe, 4'hF);
      instr = 3'b011;
      tlr = 1'b1; #1;
      chk("R9 tlr releases pads", {pad_out, pad_oe}, {core_out, core_oe});
      chk("R9 tlr drops reset request", sys_rst_req, 0);
      cyc();
      chk("R9 tlr clears hold", tctl_hold, 0);
      chk("R9 tlr clears tdo", tdo, 0);
      tlr = 1'b0; instr = 3'b000; #1;
      chk("R9 tlr cleared cells", {pad_out, pad_oe}, 8'h00);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_bypass(3'b111, "R1 bypass");
      t_edge();
      t_sample();
      t_extest();
      t_clamp();
      t_highz();
      t_tctl();
      t_undef();
      t_tlr();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule